// File: doc/BRIEF.md
# Converter Sample Pattern Checker

This block watches the sample stream a receiver hands to the application and decides whether it is a known test pattern. Each valid cycle carries one sample per converter. A select input picks the pattern. It can be one of four pseudo-random bit sequences, or an incrementing ramp. Any mismatch sets a sticky data error flag, which stays set until an external clear.

The checker carries no fixed seed. In PRBS mode it rebuilds its shift history from the bits it receives. It ignores comparisons while that history is still filling. In ramp mode it takes each converter's first valid sample as the start value. It then expects a step of one on every later valid sample. It also requires all converters to carry the same sample.

A separate per-lane checker follows a 6-bit command-channel ramp on each lane. It reports through its own sticky flag.

Top module: `pat_chk`

## Requirements
- R1: `pat_sel` encodes the pattern as follows:
  - 0 selects b[n]=b[n-6]^b[n-7] (x^7+x^6+1).
  - 1 selects b[n]=b[n-5]^b[n-9].
  - 2 selects b[n]=b[n-14]^b[n-15].
  - 3 selects b[n]=b[n-18]^b[n-23].
  - 4 to 7 select ramp mode.
  
  In PRBS mode each converter's samples form one serial stream, most significant bit first. A stream that breaks the selected recurrence sets `data_err`.
- R2: In PRBS mode, the first ceil(64/N_BITS) valid samples after reset or after a mode change are never compared. With the defaults this is 4 samples. Errors placed only inside that window never set `data_err`.
- R3: In ramp mode, the first valid sample after reset or a mode change seeds each converter and is not step-checked.
- R4: In ramp mode, every later valid sample of a converter must equal its previous valid sample plus one, wrapping from all ones to zero. Otherwise `data_err` is set.
- R5: In ramp mode, every valid cycle in which any converter's sample differs from converter 0's sets `data_err`, including the seeding cycle.
- R6: Command words are 6 bits per lane, with lane l at bits [6l+5:6l]. The first valid word seeds each lane. Each later valid word must be the previous word plus one, wrapping 0x3F to 0x00. A violation sets `cmd_err` and never `data_err`.
- R7: Both flags stay set until `err_clr` is sampled high, and are low on the following edge. The exception is a new error detected in the same cycle as the clear: it wins and leaves the flag set.
- R8: Cycles with the valid strobe low change no state. They neither advance the expected value nor seed.
- R9: A change of `pat_sel`, or reset, returns the sample checker to its unseeded state. In ramp mode the next valid sample seeds. In PRBS mode the warm-up window restarts.
- R10: Both flags are low after reset. An error appears on the first clock edge after the offending valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 3 | Pattern select (R1 encoding) |
| err_clr | input | 1 | Clears both sticky flags |
| smp_vld | input | 1 | Sample bus valid |
| smp_bus | input | M_CONV*N_BITS | Converter samples, converter c at [c*N_BITS +: N_BITS] |
| cmd_vld | input | 1 | Command word bus valid |
| cmd_bus | input | L_LANES*6 | Command words, one per lane |
| data_err | output | 1 | Sticky sample pattern error |
| cmd_err | output | 1 | Sticky command ramp error |

## Verification
Every result of this block is registered once. A mismatch, a clear or a reseed therefore shows on the flags exactly one rising edge after the cycle that carried it. The bench changes inputs on the falling edge and reads the flags on the next falling edge, so every read falls between that single edge and the next one. PRBS warm-up checks count valid samples rather than cycles, because idle cycles do not advance the window.

// File: rtl/pat_chk.sv
module pat_chk #(
  parameter int M_CONV    = 2,
  parameter int N_BITS    = 16,
  parameter int L_LANES   = 2,
  parameter int WARM_BITS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 pat_sel,
  input  logic                       err_clr,
  input  logic                       smp_vld,
  input  logic [M_CONV*N_BITS-1:0]   smp_bus,
  input  logic                       cmd_vld,
  input  logic [L_LANES*6-1:0]       cmd_bus,
  output logic                       data_err,
  output logic                       cmd_err
);
  localparam int CW   = 6;
  localparam int HW   = 23;
  localparam int XW   = HW + N_BITS;
  localparam int WARM = (WARM_BITS + N_BITS - 1) / N_BITS;
  localparam int CNTW = $clog2(WARM + 1);

  logic [2:0]        sel_q;
  logic              armed;
  logic [CNTW-1:0]   warm_cnt;
  logic [4:0]        tap_a, tap_b;
  logic [M_CONV-1:0] prbs_bad, step_bad, diff;
  logic [L_LANES-1:0] cmd_bad;
  logic              cmd_armed;

  wire              chg       = (pat_sel != sel_q);
  wire              ramp_m    = pat_sel[2];
  wire              seeded    = armed & ~chg;
  wire [CNTW-1:0]   cnt_eff   = chg ? '0 : warm_cnt;
  wire              prbs_live = (cnt_eff == CNTW'(WARM));

  always_comb begin
    case (pat_sel[1:0])
      2'd0:    begin tap_a = 5'd6;  tap_b = 5'd7;  end
      2'd1:    begin tap_a = 5'd5;  tap_b = 5'd9;  end
      2'd2:    begin tap_a = 5'd14; tap_b = 5'd15; end
      default: begin tap_a = 5'd18; tap_b = 5'd23; end
    endcase
  end

  for (genvar c = 0; c < M_CONV; c++) begin : g_conv
    logic [HW-1:0]     hist;
    logic [N_BITS-1:0] last;
    logic [N_BITS-1:0] pred;
    wire  [N_BITS-1:0] smp = smp_bus[c*N_BITS +: N_BITS];
    wire  [XW-1:0]     x   = {hist, smp};

    always_comb begin
      for (int p = 0; p < N_BITS; p++)
        pred[p] = x[p + int'(tap_a)] ^ x[p + int'(tap_b)];
    end

    assign prbs_bad[c] = |(pred ^ smp);
    assign step_bad[c] = (smp != last + N_BITS'(1));
    assign diff[c]     = (smp != smp_bus[N_BITS-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist <= '0;
        last <= '0;
      end else if (smp_vld) begin
        hist <= x[HW-1:0];
        last <= smp;
      end
    end
  end

  wire ramp_hit = ramp_m & smp_vld & (|diff | (seeded & |step_bad));
  wire prbs_hit = ~ramp_m & smp_vld & prbs_live & |prbs_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      armed    <= 1'b0;
      warm_cnt <= '0;
      data_err <= 1'b0;
    end else begin
      sel_q    <= pat_sel;
      armed    <= smp_vld | seeded;
      warm_cnt <= (smp_vld && !prbs_live) ? cnt_eff + CNTW'(1) : cnt_eff;
      data_err <= (data_err & ~err_clr) | ramp_hit | prbs_hit;
    end
  end

  for (genvar l = 0; l < L_LANES; l++) begin : g_lane
    logic [CW-1:0] prev;
    wire  [CW-1:0] w = cmd_bus[l*CW +: CW];
    assign cmd_bad[l] = cmd_armed & (w != prev + CW'(1));
    always_ff @(posedge clk) begin
      if (!rst_n)       prev <= '0;
      else if (cmd_vld) prev <= w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_armed <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      cmd_armed <= cmd_armed | cmd_vld;
      cmd_err   <= (cmd_err & ~err_clr) | (cmd_vld & |cmd_bad);
    end
  end
endmodule

// File: rtl/pat_chk_sva.sv
module pat_chk_sva #(
  parameter int M_CONV  = 2,
  parameter int N_BITS  = 16,
  parameter int L_LANES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               pat_sel,
  input logic                     err_clr,
  input logic                     smp_vld,
  input logic [M_CONV*N_BITS-1:0] smp_bus,
  input logic                     cmd_vld,
  input logic                     data_err,
  input logic                     cmd_err
);
  a_r7_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !smp_vld |=> !data_err);
  a_r7_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !cmd_vld |=> !cmd_err);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    data_err && !err_clr |=> data_err);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld && !data_err |=> !data_err);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld && !cmd_err |=> !cmd_err);
  a_r5_unequal: assert property (@(posedge clk) disable iff (!rst_n)
    pat_sel[2] && smp_vld &&
    (smp_bus[N_BITS-1:0] != smp_bus[M_CONV*N_BITS-1 -: N_BITS]) |=> data_err);
endmodule

bind pat_chk pat_chk_sva #(.M_CONV(M_CONV), .N_BITS(N_BITS), .L_LANES(L_LANES)) u_sva (
  .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .err_clr(err_clr),
  .smp_vld(smp_vld), .smp_bus(smp_bus), .cmd_vld(cmd_vld),
  .data_err(data_err), .cmd_err(cmd_err)
);

// File: tb/pat_chk_tb.sv
module pat_chk_tb;
  localparam int CLK_NS = 10;
  localparam int M = 2, N = 16, L = 2;

  logic clk = 1'b0, rst_n = 1'b0, err_clr = 1'b0, smp_vld = 1'b0, cmd_vld = 1'b0;
  logic [2:0] pat_sel = 3'd4;
  logic [M*N-1:0] smp_bus = '0;
  logic [L*6-1:0] cmd_bus = '0;
  logic data_err, cmd_err;
  int n_chk = 0, n_err = 0;
  logic [22:0] hb;

  always #(CLK_NS/2) clk = ~clk;

  pat_chk #(.M_CONV(M), .N_BITS(N), .L_LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .err_clr(err_clr),
    .smp_vld(smp_vld), .smp_bus(smp_bus), .cmd_vld(cmd_vld), .cmd_bus(cmd_bus),
    .data_err(data_err), .cmd_err(cmd_err));

  // {mode[2:0], vld, clr, conv1[15:0], conv0[15:0], expected data_err}
  localparam logic [37:0] TBL [15] = '{
    {3'd4, 1'b1, 1'b0, 16'h0005, 16'h0005, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h0006, 16'h0006, 1'b0},
    {3'd4, 1'b0, 1'b0, 16'h9999, 16'h1234, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h0007, 16'h0007, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h0009, 16'h0009, 1'b1},
    {3'd4, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h000A, 16'h000A, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h000C, 16'h000B, 1'b1},
    {3'd4, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0},
    {3'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b0},
    {3'd4, 1'b1, 1'b0, 16'h0001, 16'h0001, 1'b0},
    {3'd4, 1'b1, 1'b1, 16'h0003, 16'h0003, 1'b1},
    {3'd4, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] sel);
    rst_n = 1'b0; smp_vld = 1'b0; cmd_vld = 1'b0; err_clr = 1'b0; pat_sel = sel;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic gen(input int sel, output logic [N-1:0] s);
    int ta, tb;
    logic b;
    case (sel)
      0: begin ta = 6;  tb = 7;  end
      1: begin ta = 5;  tb = 9;  end
      2: begin ta = 14; tb = 15; end
      default: begin ta = 18; tb = 23; end
    endcase
    for (int i = N-1; i >= 0; i--) begin
      b = hb[ta-1] ^ hb[tb-1];
      s[i] = b;
      hb = {hb[21:0], b};
    end
  endtask

  task automatic send(input logic [N-1:0] s);
    smp_vld = 1'b1; smp_bus = {s, s};
    step();
    smp_vld = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] s;
    do_reset(3'd4);
    step();
    chk(data_err, 1'b0, "R10 reset data_err");
    chk(cmd_err, 1'b0, "R10 reset cmd_err");

    foreach (TBL[i]) begin
      pat_sel = TBL[i][37:35];
      smp_vld = TBL[i][34];
      err_clr = TBL[i][33];
      smp_bus = TBL[i][32:1];
      step();
      chk(data_err, TBL[i][0], $sformatf("R3/R4/R5/R7/R8/R9 ramp row %0d", i));
    end
    smp_vld = 1'b0; err_clr = 1'b0;

    for (int sel = 0; sel < 4; sel++) begin
      do_reset(3'(sel));
      hb = 23'h5A5A5;
      for (int k = 0; k < 12; k++) begin
        gen(sel, s);
        if (k == 0) s[5] = ~s[5];
        send(s);
      end
      chk(data_err, 1'b0, $sformatf("R1 R2 clean stream sel %0d", sel));
      gen(sel, s);
      s[0] = ~s[0];
      send(s);
      chk(data_err, 1'b1, $sformatf("R1 R10 flipped bit sel %0d", sel));
    end

    do_reset(3'd1);
    hb = 23'h5A5A5;
    for (int k = 0; k < 10; k++) begin gen(0, s); send(s); end
    chk(data_err, 1'b1, "R1 wrong polynomial");

    do_reset(3'd0);
    hb = 23'h5A5A5;
    for (int k = 0; k < 6; k++) begin gen(0, s); send(s); end
    pat_sel = 3'd2;
    hb = 23'h13579;
    for (int k = 0; k < 6; k++) begin gen(2, s); send(s); end
    chk(data_err, 1'b0, "R9 mode change restarts warm-up");

    do_reset(3'd4);
    cmd_vld = 1'b1; cmd_bus = {6'h3F, 6'h10}; step();
    chk(cmd_err, 1'b0, "R6 cmd seed");
    cmd_bus = {6'h00, 6'h11}; step();
    chk(cmd_err, 1'b0, "R6 cmd wrap");
    cmd_vld = 1'b0; cmd_bus = {6'h2A, 6'h05}; step();
    chk(cmd_err, 1'b0, "R8 R6 cmd idle skipped");
    cmd_vld = 1'b1; cmd_bus = {6'h01, 6'h12}; step();
    chk(cmd_err, 1'b0, "R6 cmd step");
    cmd_bus = {6'h02, 6'h14}; step();
    chk(cmd_err, 1'b1, "R6 cmd bad step");
    chk(data_err, 1'b0, "R6 data flag separate");
    cmd_vld = 1'b0; err_clr = 1'b1; step();
    err_clr = 1'b0;
    chk(cmd_err, 1'b0, "R7 cmd clear");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule